// File: doc/BRIEF.md
# Halfword-Swapping DMA Address Unit

This unit sits between a peripheral with a 16-bit data path and a 32-bit memory master port. A peripheral asks for a transfer with an address, a byte count, a direction and a swap flag. The unit ORs the address with a high-address base value supplied on an input pin. It then issues one or more memory requests and moves the data. Data travels as single bytes on the peripheral side and as 16-bit beats on the memory side.

In pass-through mode the address, the length and the byte order are left as they are. In swap mode the unit clears bit 0 of both the address and the length. It then exchanges the two bytes of every 16-bit halfword in both directions. Swap-mode writes are split into memory requests of at most `CHUNK` bytes, and the address advances by the size of each request. A single-cycle `done` pulse marks the end of each transfer. A new request is taken only while the unit is idle.

Top module: `hsd_dma_unit`

## Requirements
- R1: After reset the unit is idle. `req_ready` is high, and `done`, `mem_req_valid`, `mem_wvalid` and `rd_valid` are low. `req_ready` is high only while no transfer is in progress.
- R2: Every memory request address is `req_addr | base_addr`, plus the sizes of any earlier requests in the same transfer. In pass-through mode `mem_req_bytes` equals `req_len`.
- R3: In swap mode, bit 0 of the address and bit 0 of the length are cleared before any memory request is formed.
- R4: A request whose effective length is zero produces `done` in the cycle after acceptance and makes no memory request. This covers length 0, and length 1 in swap mode.
- R5: Pass-through byte lanes work as follows. Peripheral byte 2k maps to `mem_wdata[7:0]` or `mem_rdata[7:0]` of beat k, and byte 2k+1 maps to bits [15:8]. An odd final byte travels alone in bits [7:0], and bits [15:8] of that write beat are zero.
- R6: In swap mode, peripheral byte 2k is written to bits [15:8] of beat k, and byte 2k+1 is written to bits [7:0].
- R7: In swap mode, bits [15:8] of each read beat are delivered to the peripheral before bits [7:0].
- R8: Swap-mode writes are issued as requests of at most `CHUNK` bytes. All of them are full `CHUNK` size except the last.
- R9: Reads, and pass-through writes of any length, use exactly one memory request.
- R10: `done` is a one-cycle pulse. It rises only after every byte of the transfer has crossed both interfaces.
- R11: While stalled, a memory request holds its valid, address and size, and a write beat holds its valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Unit idle, request taken |
| req_addr | input | AW | Peripheral-supplied address |
| req_len | input | LW | Transfer length in bytes |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_swap | input | 1 | 1: halfword byte swap with forced alignment |
| base_addr | input | AW | High-address base ORed into the address |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | input | 1 | Peripheral write byte valid |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Peripheral takes read byte |
| rd_data | output | 8 | Read byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Memory request address |
| mem_req_bytes | output | LW | Memory request byte count |
| mem_req_write | output | 1 | Memory request direction |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat accepted |
| mem_wdata | output | 16 | Write beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rready | output | 1 | Read beat accepted |
| mem_rdata | input | 16 | Read beat |

## Verification
Each transfer pattern targets a different mistake:
- Odd addresses and odd lengths in both modes separate the alignment clearing from plain OR-merging. Odd pass-through lengths also expose a wrong lane for the final lone byte.
- A swap write of 150 bytes must split into 64, 64 and 22, which shows whether chunk sizing and the address stepping are correct.
- A pass-through write of 130 bytes must stay a single request, so chunking cannot leak into the wrong mode.
- Random stalls on every handshake test that held values stay put.
- Zero-length and one-byte swap requests test the path that makes no memory access, together with the timing of `done`.

// File: rtl/hsd_pkg.sv
// Shared definitions for the halfword-swapping DMA unit.
// Assumes byte-wide peripheral data and two-byte memory beats.
package hsd_pkg;
    localparam int BYTE_W     = 8;
    localparam int BEAT_BYTES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } hsd_state_e;
endpackage

// File: rtl/hsd_req_prep.sv
// Forms the effective address and length of a transfer.
// The address is ORed with the base. In swap mode bit 0 of both the
// address and the length is cleared. Purely combinational.
module hsd_req_prep #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] len_i,
    input  logic          swap_i,
    output logic [AW-1:0] eff_addr_o,
    output logic [LW-1:0] eff_len_o
);
    // Merge the base and apply forced even alignment in swap mode.
    always_comb begin
        eff_addr_o = addr_i | base_i;
        eff_len_o  = len_i;
        if (swap_i) begin
            eff_addr_o[0] = 1'b0;
            eff_len_o[0]  = 1'b0;
        end
    end
endmodule

// File: rtl/hsd_lane_swap.sv
// Reverses the byte lanes of a beat when sel_i is high. Otherwise the
// beat passes through unchanged. Combinational; LANES is the beat width
// in bytes.
module hsd_lane_swap #(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0] d_i,
    input  logic               sel_i,
    output logic [8*LANES-1:0] q_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane i takes its own byte, or the mirrored byte when swapping.
        assign q_o[8*i +: 8] = sel_i ? d_i[8*(LANES-1-i) +: 8] : d_i[8*i +: 8];
    end
endmodule

// File: rtl/hsd_chunk_size.sv
// Picks the size of the next memory request. When limit_en_i is high
// the size is capped at CHUNK bytes; otherwise the whole remaining
// length is used. Assumes CHUNK is even and fits in LW bits.
module hsd_chunk_size #(
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input  logic [LW-1:0] rem_i,
    input  logic          limit_en_i,
    output logic [LW-1:0] size_o
);
    localparam logic [LW-1:0] LIMIT = LW'(CHUNK);

    // Cap the request at the chunk limit when enabled.
    assign size_o = (limit_en_i && (rem_i > LIMIT)) ? LIMIT : rem_i;
endmodule

// File: rtl/hsd_dma_unit.sv
// Transfer engine between a byte-wide peripheral stream and a 16-bit
// memory port. It accepts one request at a time while idle, issues
// memory requests (chunked for swap-mode writes) and moves data one beat
// at a time, byte-swapping halfwords in swap mode. It assumes the memory
// side returns exactly ceil(bytes/2) read beats for each read request.
module hsd_dma_unit #(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_write,
    input  logic          req_swap,
    input  logic [AW-1:0] base_addr,
    output logic          done,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [7:0]    wr_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [7:0]    rd_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic [LW-1:0] mem_req_bytes,
    output logic          mem_req_write,
    output logic          mem_wvalid,
    input  logic          mem_wready,
    output logic [15:0]   mem_wdata,
    input  logic          mem_rvalid,
    output logic          mem_rready,
    input  logic [15:0]   mem_rdata
);
    import hsd_pkg::*;

    localparam int BW = BYTE_W * BEAT_BYTES;

    hsd_state_e    state;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] remaining;
    logic [LW-1:0] in_left;
    logic          is_write;
    logic          is_swap;
    logic [7:0]    hold_lo;
    logic          have_lo;
    logic [BW-1:0] beat_q;
    logic          beat_full;
    logic          rd_pos;
    logic          rd_two;

    logic [AW-1:0] eff_addr;
    logic [LW-1:0] eff_len;
    logic [LW-1:0] chunk;
    logic [BW-1:0] rd_swapped;
    logic [BW-1:0] wr_swapped;
    logic          in_data_wr;
    logic          in_data_rd;

    hsd_req_prep #(.AW(AW), .LW(LW)) u_prep (
        .addr_i     (req_addr),
        .base_i     (base_addr),
        .len_i      (req_len),
        .swap_i     (req_swap),
        .eff_addr_o (eff_addr),
        .eff_len_o  (eff_len)
    );

    hsd_chunk_size #(.LW(LW), .CHUNK(CHUNK)) u_chunk (
        .rem_i      (remaining),
        .limit_en_i (is_write && is_swap),
        .size_o     (chunk)
    );

    hsd_lane_swap #(.LANES(BEAT_BYTES)) u_rswap (
        .d_i   (mem_rdata),
        .sel_i (is_swap),
        .q_o   (rd_swapped)
    );

    hsd_lane_swap #(.LANES(BEAT_BYTES)) u_wswap (
        .d_i   (beat_q),
        .sel_i (is_swap),
        .q_o   (wr_swapped)
    );

    // Port views of the state machine.
    assign in_data_wr    = (state == ST_DATA) && is_write;
    assign in_data_rd    = (state == ST_DATA) && !is_write;
    assign req_ready     = (state == ST_IDLE);
    assign done          = (state == ST_DONE);
    assign mem_req_valid = (state == ST_CMD);
    assign mem_req_addr  = cur_addr;
    assign mem_req_bytes = chunk;
    assign mem_req_write = is_write;
    assign wr_ready      = in_data_wr && !beat_full && (in_left != '0);
    assign mem_wvalid    = in_data_wr && beat_full;
    assign mem_wdata     = wr_swapped;
    assign mem_rready    = in_data_rd && !beat_full;
    assign rd_valid      = in_data_rd && beat_full;
    assign rd_data       = rd_pos ? beat_q[15:8] : beat_q[7:0];

    // Sequencing of request, command, data movement and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remaining <= '0;
            in_left   <= '0;
            is_write  <= 1'b0;
            is_swap   <= 1'b0;
            hold_lo   <= '0;
            have_lo   <= 1'b0;
            beat_q    <= '0;
            beat_full <= 1'b0;
            rd_pos    <= 1'b0;
            rd_two    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_addr  <= eff_addr;
                        remaining <= eff_len;
                        is_write  <= req_write;
                        is_swap   <= req_swap;
                        state     <= (eff_len == '0) ? ST_DONE : ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (mem_req_ready) begin
                        cur_addr  <= cur_addr + AW'(chunk);
                        remaining <= remaining - chunk;
                        in_left   <= chunk;
                        state     <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (is_write) begin
                        if (wr_valid && wr_ready) begin
                            in_left <= in_left - 1'b1;
                            if (!have_lo && (in_left > LW'(1))) begin
                                hold_lo <= wr_data;
                                have_lo <= 1'b1;
                            end else begin
                                beat_q    <= have_lo ? {wr_data, hold_lo} : {8'h00, wr_data};
                                beat_full <= 1'b1;
                                have_lo   <= 1'b0;
                            end
                        end
                        if (mem_wvalid && mem_wready) begin
                            beat_full <= 1'b0;
                            if (in_left == '0) begin
                                state <= (remaining == '0) ? ST_DONE : ST_CMD;
                            end
                        end
                    end else begin
                        if (mem_rvalid && mem_rready) begin
                            beat_q    <= rd_swapped;
                            beat_full <= 1'b1;
                            rd_pos    <= 1'b0;
                            rd_two    <= (in_left > LW'(1));
                        end
                        if (rd_valid && rd_ready) begin
                            in_left <= in_left - 1'b1;
                            if (rd_pos || !rd_two) begin
                                beat_full <= 1'b0;
                                rd_pos    <= 1'b0;
                            end else begin
                                rd_pos <= 1'b1;
                            end
                            if (in_left == LW'(1)) begin
                                state <= (remaining == '0) ? ST_DONE : ST_CMD;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_wvalid || rd_valid) |-> !req_ready);

    // R3
    swap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && is_swap) |-> (!mem_req_addr[0] && !mem_req_bytes[0]));

    // R8
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && is_write && is_swap) |->
            ((mem_req_bytes <= LW'(CHUNK)) && (mem_req_bytes != '0)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes)));

    // R11
    wbeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata)));
endmodule

// File: tb/hsd_dma_unit_tb.sv
module hsd_dma_unit_tb;
    localparam int PERIOD = 10;
    localparam int AW     = 32;
    localparam int LW     = 16;
    localparam int CHUNK  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_write = 1'b0;
    logic          req_swap = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          done;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [7:0]    rd_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_bytes;
    logic          mem_req_write;
    logic          mem_wvalid;
    logic          mem_wready = 1'b0;
    logic [15:0]   mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic          mem_rready;
    logic [15:0]   mem_rdata = '0;

    hsd_dma_unit #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_swap(req_swap),
        .base_addr(base_addr), .done(done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
        .mem_req_write(mem_req_write),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata)
    );

    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state: expected traffic queues and the byte source.
    logic [AW+LW:0] exp_req[$];
    logic [15:0]    exp_wbeat[$];
    logic [7:0]     exp_rbyte[$];
    logic [7:0]     src_q[$];
    int             rpend = 0;
    int             rbeat_k = 0;
    logic [15:0]    rsalt = '0;
    int             done_cnt = 0;
    int             req_seen = 0;
    bit             stall_en = 0;
    logic [15:0]    lf = 16'hACE1;

    function automatic logic [15:0] rbeat(int k, logic [15:0] salt);
        return 16'(k * 16'h0203) ^ salt;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle memory and peripheral model, compared on every clock.
    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        mem_req_ready = stall_en ? lf[0] : 1'b1;
        mem_wready    = stall_en ? lf[3] : 1'b1;
        rd_ready      = stall_en ? lf[6] : 1'b1;
        mem_rvalid    = (rpend > 0) && (stall_en ? lf[9] : 1'b1);
        mem_rdata     = rbeat(rbeat_k, rsalt);
        wr_valid      = (src_q.size() > 0) && (stall_en ? lf[12] : 1'b1);
        wr_data       = (src_q.size() > 0) ? src_q[0] : 8'h00;
        #1;
        if (rst_n) begin
            if (mem_req_valid && mem_req_ready) begin
                req_seen++;
                if (exp_req.size() == 0)
                    chk(0, "R2 R9 unexpected memory request", {mem_req_addr, mem_req_bytes, mem_req_write}, 0);
                else begin
                    logic [AW+LW:0] e;
                    e = exp_req.pop_front();
                    chk({mem_req_addr, mem_req_bytes, mem_req_write} == e,
                        "R2 R3 R8 R9 request addr/bytes/dir", {mem_req_addr, mem_req_bytes, mem_req_write}, e);
                end
                if (!mem_req_write) begin
                    rpend = (int'(mem_req_bytes) + 1) / 2;
                    rbeat_k = 0;
                end
            end
            if (mem_wvalid && mem_wready) begin
                if (exp_wbeat.size() == 0) chk(0, "R5 R6 unexpected write beat", mem_wdata, 0);
                else begin
                    logic [15:0] e;
                    e = exp_wbeat.pop_front();
                    chk(mem_wdata == e, "R5 R6 write beat", mem_wdata, e);
                end
            end
            if (rd_valid && rd_ready) begin
                if (exp_rbyte.size() == 0) chk(0, "R5 R7 unexpected read byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rbyte.pop_front();
                    chk(rd_data == e, "R5 R7 read byte", rd_data, e);
                end
            end
            if (wr_valid && wr_ready) void'(src_q.pop_front());
            if (mem_rvalid && mem_rready) begin
                rpend--;
                rbeat_k++;
            end
            if (done) done_cnt++;
        end
    end

    // Builds expectations from the requirements, then runs one transfer.
    task automatic xfer(input logic [AW-1:0] a, input logic [AW-1:0] b, input int len,
                        input bit wr, input bit sw, input bit stall, input logic [15:0] salt);
        logic [AW-1:0] ea;
        int L, rem, c, snap, seen0, waited;
        logic [7:0] bytes[$];
        stall_en = stall;
        rsalt = salt;
        ea = a | b;
        L = len;
        if (sw) begin
            ea[0] = 1'b0;
            L = L & ~1;
        end
        if (wr) begin
            for (int i = 0; i < L; i++) bytes.push_back(8'(i * 7 + 3) ^ salt[7:0]);
            if (sw) begin
                rem = L;
                while (rem > 0) begin
                    c = (rem > CHUNK) ? CHUNK : rem;
                    exp_req.push_back({ea, LW'(c), 1'b1});
                    ea = ea + AW'(c);
                    rem = rem - c;
                end
            end else if (L > 0) exp_req.push_back({ea, LW'(L), 1'b1});
            for (int i = 0; i < L; i += 2) begin
                logic [7:0] lo, hi;
                lo = bytes[i];
                hi = (i + 1 < L) ? bytes[i+1] : 8'h00;
                exp_wbeat.push_back(sw ? {lo, hi} : {hi, lo});
            end
        end else if (L > 0) begin
            exp_req.push_back({ea, LW'(L), 1'b0});
            for (int k = 0; k < (L + 1) / 2; k++) begin
                logic [15:0] bt;
                bt = rbeat(k, salt);
                if (sw) begin
                    exp_rbyte.push_back(bt[15:8]);
                    exp_rbyte.push_back(bt[7:0]);
                end else begin
                    exp_rbyte.push_back(bt[7:0]);
                    if (2 * k + 1 < L) exp_rbyte.push_back(bt[15:8]);
                end
            end
        end
        snap = done_cnt;
        seen0 = req_seen;
        @(posedge clk);
        #2;
        req_addr = a; base_addr = b; req_len = LW'(len);
        req_write = wr; req_swap = sw; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        foreach (bytes[i]) src_q.push_back(bytes[i]);
        if (L == 0) begin
            @(negedge clk);
            #2;
            // R4: done in the cycle after acceptance, with no memory access.
            chk(done == 1'b1, "R4 done after zero-length accept", done, 1);
            chk(req_seen == seen0 && !mem_req_valid, "R4 no memory request", req_seen - seen0, 0);
        end
        waited = 0;
        while (done_cnt == snap && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_cnt != snap, "R10 transfer completes", done_cnt - snap, 1);
        // R10: everything expected has been moved by the time done fires.
        chk(exp_req.size() == 0 && exp_wbeat.size() == 0 && exp_rbyte.size() == 0,
            "R10 all traffic done at done", exp_req.size() + exp_wbeat.size() + exp_rbyte.size(), 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == snap + 1, "R10 single done pulse", done_cnt - snap, 1);
        chk(req_ready == 1'b1, "R1 idle after transfer", req_ready, 1);
        src_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1: reset state.
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(!done && !mem_req_valid && !mem_wvalid && !rd_valid, "R1 outputs quiet after reset",
            {done, mem_req_valid, mem_wvalid, rd_valid}, 0);
        xfer(32'h0000_0100, 32'h8000_0000, 5,   1, 0, 0, 16'h0011); // R2 R5 odd pass write
        xfer(32'h0000_0203, 32'h0001_0000, 7,   0, 0, 0, 16'h5A3C); // R2 R5 odd pass read
        xfer(32'h0000_0401, 32'h4000_0000, 150, 1, 1, 1, 16'h0077); // R3 R6 R8 chunked
        xfer(32'h0000_0033, 32'h0200_0000, 9,   0, 1, 1, 16'hC381); // R3 R7 swap read
        xfer(32'h0000_0800, 32'h0000_0000, 0,   1, 0, 0, 16'h0000); // R4 zero length
        xfer(32'h0000_0901, 32'h0000_1000, 1,   0, 1, 0, 16'h0000); // R4 one byte swap
        xfer(32'h0000_0C07, 32'h0100_0000, 130, 1, 0, 1, 16'h00E5); // R9 long pass write
        xfer(32'h0000_1000, 32'h0000_0000, 64,  1, 1, 1, 16'h0042); // R8 exact chunk
        xfer(32'h0000_2002, 32'h0000_0000, 2,   1, 1, 0, 16'h0019); // R6 one halfword
        xfer(32'h0000_3005, 32'h0008_0000, 1,   0, 0, 1, 16'h9E27); // R5 single byte read
        xfer(32'h0000_4000, 32'h0000_0000, 200, 0, 1, 1, 16'h6B1D); // R7 R9 long swap read
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule